// File: doc/BRIEF.md
# Reset Cause and Software Reset Request Register

This block holds one 32-bit status word that records why the system last came out of reset. Software can also use the same word to ask for a new reset. It sits at one live word inside a configuration address window. The upper five bits carry meaning and the lower 27 bits always read as zero. Three of the five bits are cause flags that software acknowledges by writing ones to them. The other two bits are soft-reset flags that software sets by writing ones to them.

Writing the soft power-on flag starts a full reset request. It also rearms the first-reset detector, so the next system reset is again classed as power-on. Writing only the soft external flag starts a reset request without rearming the detector. Each request leaves the block as a single-cycle pulse. The block does not build the reset tree; the surrounding logic does that and then signals back that a system reset took place.

The register and its saturating reset counter belong to an always-on domain. Only the power-up reset `rst` clears them. The system reset event is an input to this block and does not clear them.

Top module: `reset_cause_ctrl`

## Requirements
- R1: After power-up reset `rst`, the live word reads 0x0000_0000 and `reset_req` is low.
- R2: Bit 31 (power-on), bit 28 (button power-on) and bit 27 (button external) clear where a write to the live word carries a one. A write never sets them.
- R3: Bit 30 (soft power-on) and bit 29 (soft external) set where a write to the live word carries a one. Zeros in the write data leave them unchanged.
- R4: Bits 26:0 of write data have no effect, and bits 26:0 of read data are always zero.
- R5: An accepted write with bit 30 set gives a `reset_req` pulse in the cycle after the write, lasting exactly one cycle. The same write zeroes the reset counter, so the next system reset event loads 0x8000_0000.
- R6: An accepted write with bit 29 set and bit 30 clear gives the same one-cycle pulse but leaves the reset counter alone. A write with neither bit set gives no pulse.
- R7: A `sys_reset_event` while the counter is zero loads the register with 0x8000_0000. When the counter is non-zero the register is left unchanged. Each event increments the counter.
- R8: The counter saturates at its maximum, so any number of events after the first never loads 0x8000_0000 again without a soft power-on write.
- R9: The live word is the 8-byte-aligned pair at `BASE` with address bit 2 set. A read with address bit 2 clear returns zero, and a write with address bit 2 clear is ignored.
- R10: A read of an address outside the pair returns zero, and a write to such an address is ignored.
- R11: Read data is registered. It appears on `rd_data` in the cycle after the read access and holds until the next read.
- R12: When a write and a `sys_reset_event` arrive in the same cycle, the event is handled and the write is dropped, including its reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-up reset, synchronous, active high |
| acc_valid | input | 1 | Access strobe for one cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | ADDR_W | Byte address within the configuration window |
| acc_wdata | input | 32 | Write data |
| sys_reset_event | input | 1 | One-cycle notice that a system reset happened |
| rd_data | output | 32 | Registered read data |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The block produces three results, and each is due a fixed number of cycles after its stimulus. A register update from a write or a reset event takes effect at the clock edge that samples the stimulus. A `reset_req` pulse is high for the cycle that follows that edge. Read data is valid after the edge that samples the read. The bench drives every stimulus on a falling edge, removes it on the next falling edge, and samples outputs only at falling edges. It checks `reset_req` at the first falling edge after the write and again at the second, which confirms both the pulse and its single-cycle width. Every register result is confirmed through a later read, so each value is observed one full cycle after it was formed.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int DATA_W = 32;

    // Only the top five bits survive a write.
    localparam logic [DATA_W-1:0] KEEP_MASK  = 32'hF800_0000;
    // Cause flags acknowledged by writing ones.
    localparam logic [DATA_W-1:0] CLEAR_MASK = 32'h9800_0000;
    // Soft-reset flags set by writing ones.
    localparam logic [DATA_W-1:0] SET_MASK   = 32'h6000_0000;
    // Value loaded on the first reset after the counter was zero.
    localparam logic [DATA_W-1:0] PWR_VALUE  = 32'h8000_0000;

    typedef struct packed {
        logic        pwr_on;     // bit 31
        logic        sw_pwr_on;  // bit 30
        logic        sw_ext;     // bit 29
        logic        btn_pwr_on; // bit 28
        logic        btn_ext;    // bit 27
        logic [26:0] unused;     // bits 26:0
    } cause_t;

    typedef enum logic [1:0] {
        HIT_NONE  = 2'd0,
        HIT_LIVE  = 2'd1,
        HIT_QUIET = 2'd2
    } hit_t;

    typedef struct packed {
        logic full;   // soft power-on request
        logic light;  // soft external request
    } kick_t;

    function automatic logic [DATA_W-1:0] keep_bits(input logic [DATA_W-1:0] wd);
        return wd & KEEP_MASK;
    endfunction

    function automatic cause_t merge_write(input cause_t cur, input logic [DATA_W-1:0] wd);
        logic [DATA_W-1:0] m;
        logic [DATA_W-1:0] nxt;
        m   = keep_bits(wd);
        nxt = (DATA_W'(cur) & ~(m & CLEAR_MASK)) | (m & SET_MASK);
        nxt = nxt & KEEP_MASK;
        return cause_t'(nxt);
    endfunction

    function automatic kick_t decode_kick(input logic [DATA_W-1:0] wd);
        kick_t k;
        logic [DATA_W-1:0] m;
        m       = keep_bits(wd);
        k.full  = m[30];
        k.light = m[29] & ~m[30];
        return k;
    endfunction

endpackage

// File: rtl/rstc_decode.sv
module rstc_decode
    import rstc_pkg::*;
#(
    parameter int              ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'hF020
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output hit_t              hit,
    output logic              wr_live,
    output logic              rd_strobe
);

    localparam int PAIR_LSB = 3;

    logic in_pair;

    always_comb begin
        in_pair = (acc_addr[ADDR_W-1:PAIR_LSB] == BASE[ADDR_W-1:PAIR_LSB]);
        if (!in_pair) begin
            hit = HIT_NONE;
        end else if (acc_addr[2]) begin
            hit = HIT_LIVE;
        end else begin
            hit = HIT_QUIET;
        end
    end

    assign wr_live   = acc_valid & acc_write & (hit == HIT_LIVE);
    assign rd_strobe = acc_valid & ~acc_write;

endmodule

// File: rtl/rstc_cause_reg.sv
module rstc_cause_reg
    import rstc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_live,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sys_reset_event,
    output cause_t            cause,
    output logic [CNT_W-1:0]  cnt,
    output kick_t             kick
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    cause_t           cause_q;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;
    kick_t            wr_kick;

    // A reset event in the same cycle wins over a write.
    assign accept  = wr_live & ~sys_reset_event;
    assign wr_kick = decode_kick(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            cnt_q   <= '0;
        end else if (sys_reset_event) begin
            if (cnt_q == '0) begin
                cause_q <= cause_t'(PWR_VALUE);
            end
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (accept) begin
            cause_q <= merge_write(cause_q, wdata);
            if (wr_kick.full) begin
                cnt_q <= '0;
            end
        end
    end

    always_comb begin
        kick.full  = accept & wr_kick.full;
        kick.light = accept & wr_kick.light;
    end

    assign cause = cause_q;
    assign cnt   = cnt_q;

endmodule

// File: rtl/rstc_req_gen.sv
module rstc_req_gen
    import rstc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  kick_t kick,
    output logic  reset_req
);

    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
        end else begin
            req_q <= kick.full | kick.light;
        end
    end

    assign reset_req = req_q;

endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
    import rstc_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'hF020,
    parameter int                CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [31:0]       acc_wdata,
    input  logic              sys_reset_event,
    output logic [31:0]       rd_data,
    output logic              reset_req
);

    hit_t             hit;
    logic             wr_live;
    logic             rd_strobe;
    cause_t           cause_q;
    logic [CNT_W-1:0] cnt_q;
    kick_t            kick;
    logic [31:0]      rd_q;

    rstc_decode #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE)
    ) u_decode (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .hit       (hit),
        .wr_live   (wr_live),
        .rd_strobe (rd_strobe)
    );

    rstc_cause_reg #(
        .CNT_W (CNT_W)
    ) u_cause (
        .clk             (clk),
        .rst             (rst),
        .wr_live         (wr_live),
        .wdata           (acc_wdata),
        .sys_reset_event (sys_reset_event),
        .cause           (cause_q),
        .cnt             (cnt_q),
        .kick            (kick)
    );

    rstc_req_gen u_req (
        .clk       (clk),
        .rst       (rst),
        .kick      (kick),
        .reset_req (reset_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_strobe) begin
            rd_q <= (hit == HIT_LIVE) ? (DATA_W'(cause_q) & KEEP_MASK) : '0;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/reset_cause_ctrl_chk.sv
module reset_cause_ctrl_chk #(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'hF020,
    parameter int                CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [31:0]       acc_wdata,
    input logic              sys_reset_event,
    input logic [31:0]       rd_data,
    input logic              reset_req,
    input logic [31:0]       cause,
    input logic [CNT_W-1:0]  cnt
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic live_req_wr;
    assign live_req_wr = acc_valid && acc_write && !sys_reset_event
                      && (acc_addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]) && acc_addr[2]
                      && (acc_wdata[30] || acc_wdata[29]);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cause == 32'h0 && !reset_req)) else $error("reset state"); // R1

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[26:0] == 27'h0) else $error("low bits"); // R4

    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(live_req_wr)) else $error("request origin"); // R5

    AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        live_req_wr |=> reset_req) else $error("request missing"); // R6

    AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (rst)
        (sys_reset_event && cnt == '0) |=> cause == 32'h8000_0000) else $error("first load"); // R7

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (sys_reset_event && cnt == CNT_TOP) |=> cnt == CNT_TOP) else $error("counter wrap"); // R8

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        (sys_reset_event && cnt != '0) |=> $stable(cause)) else $error("write not dropped"); // R12

endmodule

bind reset_cause_ctrl reset_cause_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .BASE   (BASE),
    .CNT_W  (CNT_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .acc_valid       (acc_valid),
    .acc_write       (acc_write),
    .acc_addr        (acc_addr),
    .acc_wdata       (acc_wdata),
    .sys_reset_event (sys_reset_event),
    .rd_data         (rd_data),
    .reset_req       (reset_req),
    .cause           (cause_q),
    .cnt             (cnt_q)
);

// File: tb/test_reset_cause_ctrl.sv
module test_reset_cause_ctrl;

    localparam logic [15:0] LIVE  = 16'hF024;
    localparam logic [15:0] QUIET = 16'hF020;
    localparam logic [15:0] MISS  = 16'hF02C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        sys_reset_event = 1'b0;
    logic [31:0] rd_data;
    logic        reset_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    reset_cause_ctrl i_reset_cause_ctrl (
        .clk             (clk),
        .rst             (rst),
        .acc_valid       (acc_valid),
        .acc_write       (acc_write),
        .acc_addr        (acc_addr),
        .acc_wdata       (acc_wdata),
        .sys_reset_event (sys_reset_event),
        .rd_data         (rd_data),
        .reset_req       (reset_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write; checks the request pulse in the next cycle and its end a cycle later.
    task automatic wr(input string req, input logic [15:0] a, input logic [31:0] d, input bit exp_req);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        check(req, {31'b0, reset_req}, {31'b0, exp_req});
        @(negedge clk);
        check(req, {31'b0, reset_req}, 32'h0);
    endtask

    task automatic rd(input string req, input logic [15:0] a, input logic [31:0] exp);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
        check(req, rd_data, exp);
    endtask

    task automatic sys_event();
        @(negedge clk);
        sys_reset_event = 1'b1;
        @(negedge clk);
        sys_reset_event = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1", {31'b0, reset_req}, 32'h0);
        rd("R1", LIVE, 32'h0);
    endtask

    task automatic t_first_event();
        sys_event();
        rd("R7", LIVE, 32'h8000_0000);
    endtask

    task automatic t_soft_ext();
        wr("R6", LIVE, 32'h2000_0000, 1'b1);
        rd("R3", LIVE, 32'hA000_0000);
        sys_event();
        rd("R6", LIVE, 32'hA000_0000);   // counter untouched, no reload
    endtask

    task automatic t_clear_and_hold();
        wr("R2", LIVE, 32'h9800_0000, 1'b0);
        rd("R2", LIVE, 32'h2000_0000);
        wr("R3", LIVE, 32'h0000_0000, 1'b0);
        rd("R3", LIVE, 32'h2000_0000);
    endtask

    task automatic t_low_bits();
        wr("R4", LIVE, 32'h07FF_FFFF, 1'b0);
        rd("R4", LIVE, 32'h2000_0000);
    endtask

    task automatic t_soft_por();
        wr("R5", LIVE, 32'h4000_0000, 1'b1);
        rd("R5", LIVE, 32'h6000_0000);
        sys_event();
        rd("R5", LIVE, 32'h8000_0000);
    endtask

    task automatic t_quiet_word();
        wr("R9", QUIET, 32'hC000_0000, 1'b0);
        rd("R9", LIVE, 32'h8000_0000);
        rd("R9", QUIET, 32'h0);
    endtask

    task automatic t_miss();
        wr("R10", MISS, 32'hE000_0000, 1'b0);
        rd("R10", LIVE, 32'h8000_0000);
        rd("R10", MISS, 32'h0);
    endtask

    task automatic t_read_timing();
        // Back-to-back reads: each result lands after its own edge.
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = LIVE;
        @(negedge clk);
        acc_addr = QUIET;
        check("R11", rd_data, 32'h8000_0000);
        @(negedge clk);
        acc_valid = 1'b0;
        check("R11", rd_data, 32'h0);
        @(negedge clk);
        check("R11", rd_data, 32'h0);    // holds without a read
    endtask

    task automatic t_collide();
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = LIVE; acc_wdata = 32'hC000_0000;
        sys_reset_event = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; sys_reset_event = 1'b0;
        check("R12", {31'b0, reset_req}, 32'h0);
        rd("R12", LIVE, 32'h8000_0000);
    endtask

    task automatic t_saturate();
        wr("R8", LIVE, 32'h2000_0000, 1'b1);
        rd("R8", LIVE, 32'hA000_0000);
        for (int i = 0; i < 24; i++) sys_event();
        rd("R8", LIVE, 32'hA000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_first_event();
        t_soft_ext();
        t_clear_and_hold();
        t_low_bits();
        t_soft_por();
        t_quiet_word();
        t_miss();
        t_read_timing();
        t_collide();
        t_saturate();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule